// File: doc/BRIEF.md
# Bank Command State Tracker

This block watches the command stream that a memory controller sends to a DDR3-class SDRAM. It keeps a model of every internal bank and of the device-wide power mode. It judges each command against that model and against programmable row and column timings. Commands arrive on a valid/ready interface together with a bank number and a burst-chop bit. One cycle after the handshake, the block reports either acceptance or rejection, and a rejection carries a code. A rejected command changes no state. An accepted command moves the addressed bank, or every bank, along its state graph.

Each bank steps through a fixed set of states, and timed states end on their own. An opened row stays in its opening phase for tRCD cycles. A column burst occupies the bank for its latency plus half the burst length. A closing row stays in its closing phase for tRP cycles. The auto-precharge forms of read and write close the row by themselves once their burst window ends. Clock-enable low puts the device into one of two power-down variants, chosen by whether all banks are idle. A reset command returns everything to initialization from any mode.

Back-pressure: `cmd_ready` is low during power-down. It is also low in the cycle where clock-enable drops in normal operation. In both cases a reset command is the exception and is always ready. A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high, and the controller must hold a command that was not taken.

Top module: `bank_cmd_tracker`

## Requirements
- R1: After power-on reset or an accepted reset command (op 15), the next cycle shows every bank idle and the power mode at init. Bank state codes are: idle 0, opening 1, open 2, reading 3, writing 4, closing 5. Mode codes are: init 0, run 1, precharge power-down 2, active power-down 3, self refresh 4. In init, only NOP (0), MRS (9) and reset are accepted, and MRS moves the mode to run.
- R2: ACT (1) to an idle bank holds it in opening for tRCD cycles. A read or write whose handshake falls fewer than tRCD cycles after the ACT is rejected with code 1. ACT to a bank that is opening, open, reading or writing is rejected with code 3.
- R3: READ (2) or WRITE (3) to an open bank keeps it in reading or writing for CL or CWL cycles, plus 4 cycles for a burst of 8 or 2 cycles when the burst-chop bit is set, and then it returns to open. A read or write to a bank that is not open and not opening is rejected with code 4.
- R4: READ AP (4) and WRITE AP (5) behave as R3. When the burst window ends, the bank passes directly into closing for tRP cycles and then becomes idle.
- R5: PRE (6) to an open, reading or writing bank puts it in closing for tRP cycles, then idle. ACT to a closing bank is rejected with code 2. PRE to an opening bank is rejected with code 5. PRE to an idle or closing bank is accepted and changes nothing.
- R6: PREA (7) closes every open, reading or writing bank at once. It is rejected with code 5 if any bank is opening.
- R7: REF (8), MRS and SRE (10) in run need every bank idle, and are otherwise rejected with code 6. SRE enters self refresh. In self refresh, only SRX (11), NOP and reset are accepted, with SRX returning to run. SRX in run is rejected with code 7.
- R8: Clock-enable low in run enters precharge power-down if all banks are idle and active power-down otherwise. Clock-enable high in power-down returns to run with the bank states kept. `cmd_ready` is low during power-down and while clock-enable is low in run, except for the reset op.
- R9: For each handshake, exactly one of `cmd_ok` and `cmd_err` pulses in the next cycle. `err_code` is 0 with `cmd_ok` and non-zero with `cmd_err`. Unlisted op codes are rejected with code 7. A rejected command changes no bank and no mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cke | input | 1 | Device clock-enable as driven by the controller |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take the command this cycle |
| cmd_op | input | 4 | Decoded command code |
| cmd_bank | input | BW | Target bank |
| cmd_bc4 | input | 1 | Burst chop for this read or write |
| t_rcd | input | TW | Row-to-column delay in cycles |
| t_rp | input | TW | Precharge time in cycles |
| t_cl | input | TW | Read latency in cycles |
| t_cwl | input | TW | Write latency in cycles |
| bank_state | output | 3*NB | State code of each bank, bank 0 in the low bits |
| pwr_mode | output | 3 | Device-wide mode code |
| cmd_ok | output | 1 | Previous handshake accepted |
| cmd_err | output | 1 | Previous handshake rejected |
| err_code | output | 3 | Reason for the rejection |

## Verification
A directed walk starts with a command in init and then steps through row open, early column access, the busy window, closing, closing-time violation, all-bank close while a row is opening, refresh with a row open, both power-down variants, self refresh, and reset from power-down. Each step hits exactly one rejection code or one transition. The walk therefore shows whether each code is tied to its own cause rather than to a neighbour's. After that, seeded random ops are issued at random banks, with random clock-enable drops and timing sets that change every 200 cycles. These runs are compared each cycle against a bench model. This separates counter off-by-one errors at tRCD, tRP and burst boundaries of 1 and 2 from errors in the bank-selection and auto-precharge paths.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_ACT  = 4'd1;
  localparam logic [3:0] OP_RD   = 4'd2;
  localparam logic [3:0] OP_WR   = 4'd3;
  localparam logic [3:0] OP_RDA  = 4'd4;
  localparam logic [3:0] OP_WRA  = 4'd5;
  localparam logic [3:0] OP_PRE  = 4'd6;
  localparam logic [3:0] OP_PREA = 4'd7;
  localparam logic [3:0] OP_REF  = 4'd8;
  localparam logic [3:0] OP_MRS  = 4'd9;
  localparam logic [3:0] OP_SRE  = 4'd10;
  localparam logic [3:0] OP_SRX  = 4'd11;
  localparam logic [3:0] OP_RST  = 4'd15;

  typedef enum logic [2:0] {
    BK_IDLE    = 3'd0,
    BK_OPENING = 3'd1,
    BK_OPEN    = 3'd2,
    BK_RD      = 3'd3,
    BK_WR      = 3'd4,
    BK_CLOSING = 3'd5
  } bank_st_e;

  typedef enum logic [2:0] {
    PM_INIT    = 3'd0,
    PM_RUN     = 3'd1,
    PM_PDN_PRE = 3'd2,
    PM_PDN_ACT = 3'd3,
    PM_SELF    = 3'd4
  } pwr_mode_e;

  localparam logic [2:0] E_NONE        = 3'd0;
  localparam logic [2:0] E_TRCD        = 3'd1;
  localparam logic [2:0] E_TRP         = 3'd2;
  localparam logic [2:0] E_ROW_BUSY    = 3'd3;
  localparam logic [2:0] E_NOT_OPEN    = 3'd4;
  localparam logic [2:0] E_PRE_OPENING = 3'd5;
  localparam logic [2:0] E_NEED_IDLE   = 3'd6;
  localparam logic [2:0] E_BAD_MODE    = 3'd7;

endpackage

// File: rtl/bank_fsm.sv
module bank_fsm
  import bank_trk_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          act,
  input  logic          cas_rd,
  input  logic          cas_wr,
  input  logic          cas_ap,
  input  logic          cas_bc4,
  input  logic          pre,
  input  logic [TW-1:0] t_rcd,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_cl,
  input  logic [TW-1:0] t_cwl,
  output bank_st_e      state
);

  localparam int CW = TW + 2;

  logic [CW-1:0] cnt;
  logic          ap_q;
  logic [CW-1:0] burst_len;
  logic [CW-1:0] rd_len;
  logic [CW-1:0] wr_len;
  bank_st_e      close_st;
  logic [CW-1:0] close_cnt;

  always_comb begin
    burst_len = cas_bc4 ? CW'(2) : CW'(4);
    rd_len    = CW'(t_cl) + burst_len - CW'(1);
    wr_len    = CW'(t_cwl) + burst_len - CW'(1);
    close_st  = (t_rp > TW'(1)) ? BK_CLOSING : BK_IDLE;
    close_cnt = CW'(t_rp) - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BK_IDLE;
      cnt   <= '0;
      ap_q  <= 1'b0;
    end else if (clr) begin
      state <= BK_IDLE;
      cnt   <= '0;
      ap_q  <= 1'b0;
    end else if (act) begin
      if (t_rcd > TW'(1)) begin
        state <= BK_OPENING;
        cnt   <= CW'(t_rcd) - CW'(1);
      end else begin
        state <= BK_OPEN;
      end
    end else if (cas_rd || cas_wr) begin
      state <= cas_rd ? BK_RD : BK_WR;
      cnt   <= cas_rd ? rd_len : wr_len;
      ap_q  <= cas_ap;
    end else if (pre) begin
      state <= close_st;
      cnt   <= close_cnt;
    end else begin
      case (state)
        BK_OPENING: begin
          if (cnt <= CW'(1)) state <= BK_OPEN;
          else               cnt   <= cnt - CW'(1);
        end
        BK_RD, BK_WR: begin
          if (cnt <= CW'(1)) begin
            ap_q <= 1'b0;
            if (ap_q) begin
              state <= close_st;
              cnt   <= close_cnt;
            end else begin
              state <= BK_OPEN;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        BK_CLOSING: begin
          if (cnt <= CW'(1)) state <= BK_IDLE;
          else               cnt   <= cnt - CW'(1);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cmd_rules.sv
module cmd_rules
  import bank_trk_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 3
) (
  input  pwr_mode_e             mode,
  input  logic [3:0]            op,
  input  logic [BW-1:0]         bank,
  input  logic                  cke,
  input  logic                  valid,
  input  logic [NB-1:0][2:0]    banks,
  output logic                  ready,
  output logic                  take,
  output logic                  legal,
  output logic [2:0]            code,
  output logic                  all_idle
);

  logic     any_opening;
  bank_st_e sel_st;
  logic     in_pdn;

  always_comb begin
    all_idle    = 1'b1;
    any_opening = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (banks[b] != BK_IDLE)    all_idle    = 1'b0;
      if (banks[b] == BK_OPENING) any_opening = 1'b1;
    end
  end

  assign sel_st = bank_st_e'(banks[bank]);
  assign in_pdn = (mode == PM_PDN_PRE) || (mode == PM_PDN_ACT);
  assign ready  = (op == OP_RST) || !(in_pdn || ((mode == PM_RUN) && !cke));
  assign take   = valid && ready;

  always_comb begin
    code = E_NONE;
    if (op != OP_RST) begin
      case (mode)
        PM_INIT: if (op != OP_NOP && op != OP_MRS) code = E_BAD_MODE;
        PM_SELF: if (op != OP_NOP && op != OP_SRX) code = E_BAD_MODE;
        PM_RUN: begin
          case (op)
            OP_NOP: code = E_NONE;
            OP_ACT: begin
              if (sel_st == BK_CLOSING)   code = E_TRP;
              else if (sel_st != BK_IDLE) code = E_ROW_BUSY;
            end
            OP_RD, OP_WR, OP_RDA, OP_WRA: begin
              if (sel_st == BK_OPENING)   code = E_TRCD;
              else if (sel_st != BK_OPEN) code = E_NOT_OPEN;
            end
            OP_PRE:  if (sel_st == BK_OPENING) code = E_PRE_OPENING;
            OP_PREA: if (any_opening)          code = E_PRE_OPENING;
            OP_REF, OP_MRS, OP_SRE: if (!all_idle) code = E_NEED_IDLE;
            default: code = E_BAD_MODE;
          endcase
        end
        default: code = E_BAD_MODE;
      endcase
    end
  end

  assign legal = (code == E_NONE);

endmodule

// File: rtl/bank_cmd_tracker.sv
module bank_cmd_tracker
  import bank_trk_pkg::*;
#(
  parameter int NB = 8,
  parameter int TW = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [3:0]      cmd_op,
  input  logic [BW-1:0]   cmd_bank,
  input  logic            cmd_bc4,
  input  logic [TW-1:0]   t_rcd,
  input  logic [TW-1:0]   t_rp,
  input  logic [TW-1:0]   t_cl,
  input  logic [TW-1:0]   t_cwl,
  output logic [NB*3-1:0] bank_state,
  output logic [2:0]      pwr_mode,
  output logic            cmd_ok,
  output logic            cmd_err,
  output logic [2:0]      err_code
);

  bank_st_e           st [NB];
  logic [NB-1:0][2:0] st_vec;
  pwr_mode_e          mode_q;
  logic               take;
  logic               legal;
  logic [2:0]         code;
  logic               all_idle;
  logic               do_ok;
  logic               is_rd;
  logic               is_wr;
  logic               is_ap;

  cmd_rules #(.NB(NB), .BW(BW)) u_rules (
    .mode     (mode_q),
    .op       (cmd_op),
    .bank     (cmd_bank),
    .cke      (cke),
    .valid    (cmd_valid),
    .banks    (st_vec),
    .ready    (cmd_ready),
    .take     (take),
    .legal    (legal),
    .code     (code),
    .all_idle (all_idle)
  );

  assign do_ok = take && legal;
  assign is_rd = (cmd_op == OP_RD) || (cmd_op == OP_RDA);
  assign is_wr = (cmd_op == OP_WR) || (cmd_op == OP_WRA);
  assign is_ap = (cmd_op == OP_RDA) || (cmd_op == OP_WRA);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    logic row_up;
    assign sel    = (cmd_bank == BW'(b));
    assign row_up = (st[b] == BK_OPEN) || (st[b] == BK_RD) || (st[b] == BK_WR);

    bank_fsm #(.TW(TW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (take && (cmd_op == OP_RST)),
      .act     (do_ok && sel && (cmd_op == OP_ACT)),
      .cas_rd  (do_ok && sel && is_rd),
      .cas_wr  (do_ok && sel && is_wr),
      .cas_ap  (is_ap),
      .cas_bc4 (cmd_bc4),
      .pre     (do_ok && row_up && (((cmd_op == OP_PRE) && sel) || (cmd_op == OP_PREA))),
      .t_rcd   (t_rcd),
      .t_rp    (t_rp),
      .t_cl    (t_cl),
      .t_cwl   (t_cwl),
      .state   (st[b])
    );

    assign st_vec[b]            = st[b];
    assign bank_state[b*3 +: 3] = st[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_INIT;
    end else if (take && (cmd_op == OP_RST)) begin
      mode_q <= PM_INIT;
    end else begin
      case (mode_q)
        PM_INIT: if (do_ok && cmd_op == OP_MRS) mode_q <= PM_RUN;
        PM_RUN: begin
          if (!cke)                               mode_q <= all_idle ? PM_PDN_PRE : PM_PDN_ACT;
          else if (do_ok && cmd_op == OP_SRE)     mode_q <= PM_SELF;
        end
        PM_PDN_PRE, PM_PDN_ACT: if (cke) mode_q <= PM_RUN;
        PM_SELF: if (do_ok && cmd_op == OP_SRX) mode_q <= PM_RUN;
        default: mode_q <= PM_INIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ok   <= 1'b0;
      cmd_err  <= 1'b0;
      err_code <= E_NONE;
    end else begin
      cmd_ok   <= take && legal;
      cmd_err  <= take && !legal;
      err_code <= take ? code : E_NONE;
    end
  end

  assign pwr_mode = mode_q;

endmodule

// File: rtl/bank_trk_chk.sv
module bank_trk_chk
  import bank_trk_pkg::*;
#(
  parameter int NB = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [3:0]      cmd_op,
  input logic [NB*3-1:0] bank_state,
  input logic [2:0]      pwr_mode,
  input logic            cmd_ok,
  input logic            cmd_err,
  input logic [2:0]      err_code
);

  // R9
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ok && cmd_err));

  // R9
  result_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok || cmd_err) |-> $past(cmd_valid && cmd_ready));

  // R9
  code_matches_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (err_code != E_NONE));

  // R9
  code_zero_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_err |-> (err_code == E_NONE));

  // R1
  rst_cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_RST) |=>
      (pwr_mode == PM_INIT && bank_state == '0));

  // R8
  pdn_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_mode == PM_PDN_PRE || pwr_mode == PM_PDN_ACT) && cmd_op != OP_RST) |-> !cmd_ready);

  for (genvar b = 0; b < NB; b++) begin : g_bk
    // R2
    opening_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state[b*3 +: 3] == BK_OPENING) |=>
        (bank_state[b*3 +: 3] == BK_OPENING || bank_state[b*3 +: 3] == BK_OPEN ||
         bank_state[b*3 +: 3] == BK_IDLE));
    // R5
    closing_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state[b*3 +: 3] == BK_CLOSING) |=>
        (bank_state[b*3 +: 3] == BK_CLOSING || bank_state[b*3 +: 3] == BK_IDLE));
  end

endmodule

bind bank_cmd_tracker bank_trk_chk #(.NB(NB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .bank_state (bank_state),
  .pwr_mode   (pwr_mode),
  .cmd_ok     (cmd_ok),
  .cmd_err    (cmd_err),
  .err_code   (err_code)
);

// File: tb/bank_cmd_tracker_tb.sv
module bank_cmd_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int TW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cke = 1'b1;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [3:0]      cmd_op = '0;
  logic [2:0]      cmd_bank = '0;
  logic            cmd_bc4 = 1'b0;
  logic [TW-1:0]   t_rcd = 4'd3, t_rp = 4'd2, t_cl = 4'd5, t_cwl = 4'd4;
  logic [NB*3-1:0] bank_state;
  logic [2:0]      pwr_mode;
  logic            cmd_ok, cmd_err;
  logic [2:0]      err_code;

  bank_cmd_tracker #(.NB(NB), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_bc4(cmd_bc4),
    .t_rcd(t_rcd), .t_rp(t_rp), .t_cl(t_cl), .t_cwl(t_cwl),
    .bank_state(bank_state), .pwr_mode(pwr_mode),
    .cmd_ok(cmd_ok), .cmd_err(cmd_err), .err_code(err_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model of the requirements
  int mst [NB];
  int mcnt [NB];
  bit map_ [NB];
  int mmode;
  int e_ok, e_err, e_code, e_rdy;

  function automatic void chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endfunction

  function automatic void close_bank(int b);
    if (t_rp > 1) begin mst[b] = 5; mcnt[b] = int'(t_rp) - 1; end
    else mst[b] = 0;
  endfunction

  function automatic void tick_bank(int b);
    case (mst[b])
      1: if (mcnt[b] <= 1) mst[b] = 2; else mcnt[b]--;
      3, 4: if (mcnt[b] <= 1) begin
              if (map_[b]) close_bank(b); else mst[b] = 2;
              map_[b] = 0;
            end else mcnt[b]--;
      5: if (mcnt[b] <= 1) mst[b] = 0; else mcnt[b]--;
      default: ;
    endcase
  endfunction

  function automatic int rule(int op, int bk, bit allidle, bit anyopen);
    int s = mst[bk];
    if (op == 15) return 0;
    case (mmode)
      0: return (op == 0 || op == 9) ? 0 : 7;
      4: return (op == 0 || op == 11) ? 0 : 7;
      1: case (op)
           0: return 0;
           1: return (s == 0) ? 0 : (s == 5) ? 2 : 3;
           2, 3, 4, 5: return (s == 2) ? 0 : (s == 1) ? 1 : 4;
           6: return (s == 1) ? 5 : 0;
           7: return anyopen ? 5 : 0;
           8, 9, 10: return allidle ? 0 : 6;
           default: return 7;
         endcase
      default: return 7;
    endcase
  endfunction

  function automatic void model_step(int op, int bk, bit bc4, bit vld, bit ck);
    bit allidle = 1, anyopen = 0, take, ok;
    int code;
    for (int b = 0; b < NB; b++) begin
      if (mst[b] != 0) allidle = 0;
      if (mst[b] == 1) anyopen = 1;
    end
    e_rdy = (op == 15) || !((mmode == 2) || (mmode == 3) || (mmode == 1 && !ck));
    take = vld && e_rdy;
    code = rule(op, bk, allidle, anyopen);
    ok = take && code == 0;
    e_ok = ok; e_err = take && code != 0; e_code = take ? code : 0;
    for (int b = 0; b < NB; b++) begin
      bit up = (mst[b] == 2 || mst[b] == 3 || mst[b] == 4);
      if (take && op == 15) begin mst[b] = 0; mcnt[b] = 0; map_[b] = 0; end
      else if (ok && op == 1 && b == bk) begin
        if (t_rcd > 1) begin mst[b] = 1; mcnt[b] = int'(t_rcd) - 1; end else mst[b] = 2;
      end else if (ok && op >= 2 && op <= 5 && b == bk) begin
        bit rd = (op == 2 || op == 4);
        mst[b] = rd ? 3 : 4;
        mcnt[b] = (rd ? int'(t_cl) : int'(t_cwl)) + (bc4 ? 2 : 4) - 1;
        map_[b] = (op >= 4);
      end else if (ok && up && ((op == 6 && b == bk) || op == 7)) close_bank(b);
      else tick_bank(b);
    end
    if (take && op == 15) mmode = 0;
    else case (mmode)
      0: if (ok && op == 9) mmode = 1;
      1: if (!ck) mmode = allidle ? 2 : 3; else if (ok && op == 10) mmode = 4;
      2, 3: if (ck) mmode = 1;
      4: if (ok && op == 11) mmode = 1;
      default: ;
    endcase
  endfunction

  function automatic string tag_of(int op, bit ck, int md);
    if (op == 15) return "R1";
    if (!ck || md == 2 || md == 3) return "R8";
    case (op)
      1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      6: return "R5";
      7: return "R6";
      8, 9, 10, 11: return "R7";
      default: return "R9";
    endcase
  endfunction

  // called at a falling edge; returns at the next falling edge after comparing
  task automatic drive(int op, int bk, bit bc4, bit vld, bit ck);
    string tg = tag_of(op, ck, mmode);
    logic [NB*3-1:0] ev;
    cmd_op = 4'(op); cmd_bank = 3'(bk); cmd_bc4 = bc4; cmd_valid = vld; cke = ck;
    #1;
    model_step(op, bk, bc4, vld, ck);
    chk(tg, "cmd_ready", int'(cmd_ready), e_rdy);
    @(negedge clk);
    for (int b = 0; b < NB; b++) ev[b*3 +: 3] = 3'(mst[b]);
    chk(tg, "bank_state", int'(bank_state), int'(ev));
    chk(tg, "pwr_mode", int'(pwr_mode), mmode);
    chk("R9", "cmd_ok", int'(cmd_ok), e_ok);
    chk("R9", "cmd_err", int'(cmd_err), e_err);
    chk("R9", "err_code", int'(err_code), e_code);
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 1);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin mst[b] = 0; mcnt[b] = 0; map_[b] = 0; end
    mmode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "reset bank_state", int'(bank_state), 0);
    chk("R1", "reset pwr_mode", int'(pwr_mode), 0);
    chk("R1", "reset cmd_ok", int'(cmd_ok), 0);
    chk("R1", "reset cmd_err", int'(cmd_err), 0);

    // R1 ACT in init is rejected, MRS enters run
    drive(1, 2, 0, 1, 1);
    chk("R1", "ACT in init code", int'(err_code), 7);
    drive(9, 0, 0, 1, 1);
    chk("R1", "MRS to run", int'(pwr_mode), 1);

    // R2 early read after ACT (tRCD=3)
    drive(1, 2, 0, 1, 1);
    drive(2, 2, 0, 1, 1);
    chk("R2", "early read code", int'(err_code), 1);
    drive(0, 0, 0, 1, 1);
    drive(2, 2, 0, 1, 1);
    chk("R2", "read at tRCD accepted", int'(cmd_ok), 1);
    chk("R3", "bank2 reading", int'(bank_state[8:6]), 3);
    // R3 write to busy bank
    drive(3, 2, 0, 1, 1);
    chk("R3", "write while reading code", int'(err_code), 4);
    // R2 ACT to busy bank
    drive(1, 2, 0, 1, 1);
    chk("R2", "ACT busy code", int'(err_code), 3);
    idle_n(8);
    chk("R3", "back to open", int'(bank_state[8:6]), 2);

    // R5 PRE then ACT inside tRP (tRP=2)
    drive(6, 2, 0, 1, 1);
    drive(1, 2, 0, 1, 1);
    chk("R5", "ACT while closing code", int'(err_code), 2);
    drive(1, 2, 0, 1, 1);
    chk("R5", "ACT after tRP ok", int'(cmd_ok), 1);
    // R5 PRE on opening bank, R6 PREA with a bank opening
    drive(6, 2, 0, 1, 1);
    chk("R5", "PRE opening code", int'(err_code), 5);
    drive(7, 0, 0, 1, 1);
    chk("R6", "PREA opening code", int'(err_code), 5);
    idle_n(2);
    // R7 refresh with a row open
    drive(8, 0, 0, 1, 1);
    chk("R7", "REF not idle code", int'(err_code), 6);
    // R8 active power-down
    drive(0, 0, 0, 0, 0);
    chk("R8", "active power-down", int'(pwr_mode), 3);
    drive(1, 5, 0, 1, 0);
    chk("R8", "held in power-down", int'(cmd_ok) + int'(cmd_err), 0);
    drive(0, 0, 0, 0, 1);
    chk("R8", "exit keeps bank open", int'(bank_state[8:6]), 2);
    // R4 auto-precharge read with burst chop
    drive(4, 2, 1, 1, 1);
    idle_n(10);
    chk("R4", "auto-precharge to idle", int'(bank_state[8:6]), 0);
    drive(0, 0, 0, 0, 0);
    chk("R8", "precharge power-down", int'(pwr_mode), 2);
    drive(0, 0, 0, 0, 1);
    // R7 self refresh
    drive(10, 0, 0, 1, 1);
    chk("R7", "self refresh", int'(pwr_mode), 4);
    drive(1, 1, 0, 1, 1);
    chk("R7", "ACT in self refresh code", int'(err_code), 7);
    drive(11, 0, 0, 1, 1);
    chk("R7", "SRX to run", int'(pwr_mode), 1);
    // R9 unlisted op
    drive(13, 0, 0, 1, 1);
    chk("R9", "unlisted op code", int'(err_code), 7);
    // R1 reset from power-down
    drive(1, 3, 0, 1, 1);
    drive(0, 0, 0, 0, 0);
    drive(15, 0, 0, 1, 0);
    chk("R1", "reset from power-down", int'(pwr_mode), 0);
    chk("R1", "reset banks idle", int'(bank_state), 0);

    // seeded random phase
    void'($urandom(32'd4711));
    for (int blk = 0; blk < 20; blk++) begin
      t_rcd = 4'($urandom_range(13, 1));
      t_rp  = 4'($urandom_range(13, 1));
      t_cl  = 4'($urandom_range(13, 1));
      t_cwl = 4'($urandom_range(13, 1));
      for (int i = 0; i < 200; i++) begin
        int r = $urandom_range(99, 0);
        int op;
        int bk = ($urandom_range(1, 0) != 0) ? $urandom_range(3, 0) : $urandom_range(7, 0);
        if (r < 18) op = 1; else if (r < 30) op = 2; else if (r < 40) op = 3;
        else if (r < 46) op = 4; else if (r < 52) op = 5; else if (r < 60) op = 6;
        else if (r < 64) op = 7; else if (r < 67) op = 8; else if (r < 72) op = 9;
        else if (r < 75) op = 10; else if (r < 79) op = 11; else if (r < 80) op = 15;
        else if (r < 82) op = 13; else op = 0;
        drive(op, bk, 1'($urandom_range(1, 0)), ($urandom_range(99, 0) < 75),
              ($urandom_range(99, 0) >= 4));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule